// File: doc/BRIEF.md
# Character Display Timing Sequencer

This block turns a dot clock, already locked to the horizontal sync of a monitor, into the pixel position of an on-screen character overlay. The overlay is a grid of 15 memory rows by 30 memory columns of 10-dot-wide glyph cells with 16 glyph lines each. The horizontal and vertical flyback pulses are active low. Their falling edges restart the dot count and the scan-line count. Two delay inputs place the overlay on screen, one in steps of 5 dots and one in steps of 4 scan lines. A height input stretches each character row to between 16 and 63 scan lines.

For every dot the block reports which memory row and column are being drawn, which glyph line and glyph dot inside that cell apply, and whether the dot lies in the active display. Per-row flags double a row's height or width. Doubling remaps memory rows and columns onto the screen. A resolution select sets how many dots fit in a line, and dots beyond that count are blanked. An auxiliary clock output at a tenth of the dot rate, aligned to horizontal sync, can drive an external pulse-width modulator.

Top module: `osd_timing_seq`

## Requirements
- R1: After reset, and until the first horizontal flyback falling edge, `active` and `pwm_clk` are both 0.
- R2: Let P be the dot clock edge that first samples `hflb_n` low, and let HS = `hdelay`×5+47. The first active dot of a displayed line is visible after edge P+HS. The active run lasts exactly 300 dots when the line is long enough.
- R3: Let VS = `vdelay`×4+1. Glyph line 0 of memory row 0 is shown on the scan line that starts at the VS-th horizontal flyback falling edge after a vertical flyback falling edge.
- R4: In a normal-width row, with x the dot offset from the start of the active run, `mem_col` = x/10 and `glyph_dot` = x mod 10.
- R5: In a row whose `row_dbl_w` bit is set, `mem_col` = 2×(x/20) and `glyph_dot` = (x mod 20)/2, so only even columns appear, each two dots per glyph dot.
- R6: A normal-height row lasts `char_h` scan lines (16 to 63). On scan line y of the row, `glyph_line` = floor(y×16/`char_h`).
- R7: A row whose `row_dbl_h` bit is set lasts 2×`char_h` scan lines, with `glyph_line` = floor(y×8/`char_h`). Every later memory row starts that many lines further down.
- R8: Dots at or beyond the line length are blanked. The line length is set by `res_sel`: bit 0 clear gives 320, bit 0 set with bit 1 clear gives 480, and both set gives 640. Dots are counted from P.
- R9: While `pwm_en` is 1, `pwm_clk` is high for 5 dots and low for 5 dots starting at P, for the first line-length dots of the line, which gives 32, 48 or 64 periods. It is 0 otherwise, and always 0 while `pwm_en` is 0.
- R10: After the last scan line of memory row 14 no further line is active. A vertical flyback falling edge clears `active` on the next dot and restarts the row sequence.
- R11: The dot after edge P is never active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, locked to horizontal sync |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| hflb_n | input | 1 | Horizontal flyback pulse, active low |
| vflb_n | input | 1 | Vertical flyback pulse, active low |
| vdelay | input | 8 | Vertical start, in steps of 4 scan lines (non-zero) |
| hdelay | input | 7 | Horizontal start, in steps of 5 dots (non-zero) |
| char_h | input | 6 | Scan lines per character row, 16 to 63 |
| res_sel | input | 2 | Line length select (bit 0 extend, bit 1 full) |
| pwm_en | input | 1 | Enables the auxiliary clock output |
| row_dbl_h | input | 15 | Per memory row double-height flags |
| row_dbl_w | input | 15 | Per memory row double-width flags |
| mem_row | output | 4 | Memory row being drawn |
| mem_col | output | 5 | Memory column being drawn |
| glyph_line | output | 4 | Glyph line index, 0 to 15 |
| glyph_dot | output | 4 | Glyph dot index, 0 to 9 |
| active | output | 1 | Dot lies in the active display |
| pwm_clk | output | 1 | Auxiliary clock, dot clock divided by 10 |

## Verification
The properties assume that the two flyback falling edges never arrive on the same dot clock edge. They also assume that the row flags stay constant across any scan line, so that the column stepping of one row is not mixed with another. The stimulus meets both assumptions. It changes the delays, the height, the line length and the row flags only just before a vertical flyback pulse, and only after the active run of the previous line has ended. It starts every flyback pulse at a line boundary with the other pulse released. It always sets `char_h` to at least 16 and keeps both delay values non-zero.

// File: rtl/osd_timing_seq.sv
module osd_timing_seq #(
  parameter int ROWS    = 15,
  parameter int COLS    = 30,
  parameter int CELL_W  = 10,
  parameter int GLYPH_H = 16,
  parameter int PWM_DIV = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hflb_n,
  input  logic                       vflb_n,
  input  logic [7:0]                 vdelay,
  input  logic [6:0]                 hdelay,
  input  logic [5:0]                 char_h,
  input  logic [1:0]                 res_sel,
  input  logic                       pwm_en,
  input  logic [ROWS-1:0]            row_dbl_h,
  input  logic [ROWS-1:0]            row_dbl_w,
  output logic [$clog2(ROWS)-1:0]    mem_row,
  output logic [$clog2(COLS)-1:0]    mem_col,
  output logic [$clog2(GLYPH_H)-1:0] glyph_line,
  output logic [$clog2(CELL_W)-1:0]  glyph_dot,
  output logic                       active,
  output logic                       pwm_clk
);
  localparam int RW  = $clog2(ROWS);
  localparam int CW  = $clog2(COLS);
  localparam int GW  = $clog2(GLYPH_H);
  localparam int DW  = $clog2(CELL_W);
  localparam int PW  = $clog2(PWM_DIV);
  localparam int HCW = 11;
  localparam int LCW = 11;

  logic hflb_q, vflb_q;
  wire  h_edge = hflb_q & ~hflb_n;
  wire  v_edge = vflb_q & ~vflb_n;

  logic [HCW-1:0] hcnt;
  logic [LCW-1:0] lcnt;
  logic [PW-1:0]  pcnt;
  logic [HCW-1:0] line_dots;

  wire [HCW-1:0] h_start = HCW'(hdelay) * HCW'(5) + HCW'(47);
  wire [LCW-1:0] v_start = LCW'({vdelay, 2'b00}) + LCW'(1);

  always_comb begin
    case (res_sel)
      2'b01:   line_dots = HCW'(480);
      2'b11:   line_dots = HCW'(640);
      default: line_dots = HCW'(320);
    endcase
  end

  wire in_line = hcnt < line_dots;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hflb_q <= 1'b1;
      vflb_q <= 1'b1;
    end else begin
      hflb_q <= hflb_n;
      vflb_q <= vflb_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '1;
      pcnt <= '0;
    end else if (h_edge) begin
      hcnt <= '0;
      pcnt <= '0;
    end else begin
      if (hcnt != '1) hcnt <= hcnt + HCW'(1);
      pcnt <= (pcnt == PW'(PWM_DIV-1)) ? '0 : pcnt + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   lcnt <= '0;
    else if (v_edge)              lcnt <= '0;
    else if (h_edge && lcnt != '1) lcnt <= lcnt + LCW'(1);
  end

  logic          vact, dh_half;
  logic [RW-1:0] mrow;
  logic [5:0]    sline;
  logic [5:0]    gacc;
  logic [GW-1:0] gline;

  wire       cur_dh = row_dbl_h[mrow];
  wire       cur_dw = row_dbl_w[mrow];
  wire [6:0] gsum   = {1'b0, gacc} + (cur_dh ? 7'(GLYPH_H/2) : 7'(GLYPH_H));
  wire       g_wrap = gsum >= {1'b0, char_h};
  wire       row_end = sline == (char_h - 6'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vact    <= 1'b0;
      dh_half <= 1'b0;
      mrow    <= '0;
      sline   <= '0;
      gacc    <= '0;
      gline   <= '0;
    end else if (v_edge) begin
      vact <= 1'b0;
    end else if (h_edge) begin
      if (!vact && (lcnt + LCW'(1) == v_start)) begin
        vact    <= 1'b1;
        dh_half <= 1'b0;
        mrow    <= '0;
        sline   <= '0;
        gacc    <= '0;
        gline   <= '0;
      end else if (vact) begin
        if (row_end && !(cur_dh && !dh_half)) begin
          sline   <= '0;
          dh_half <= 1'b0;
          gacc    <= '0;
          gline   <= '0;
          if (mrow == RW'(ROWS-1)) vact <= 1'b0;
          else                     mrow <= mrow + RW'(1);
        end else begin
          if (row_end) begin
            sline   <= '0;
            dh_half <= 1'b1;
          end else begin
            sline <= sline + 6'd1;
          end
          if (g_wrap) begin
            gacc  <= 6'(gsum - {1'b0, char_h});
            gline <= gline + GW'(1);
          end else begin
            gacc <= gsum[5:0];
          end
        end
      end
    end
  end

  logic          hact, wph;
  logic [DW-1:0] dcnt;
  logic [CW-1:0] ccnt;

  wire        h_step   = ~cur_dw | wph;
  wire [CW:0] col_next = {1'b0, ccnt} + (cur_dw ? (CW+1)'(2) : (CW+1)'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hact <= 1'b0;
      wph  <= 1'b0;
      dcnt <= '0;
      ccnt <= '0;
    end else if (h_edge) begin
      hact <= 1'b0;
    end else if (!hact && (hcnt == h_start - HCW'(1))) begin
      hact <= 1'b1;
      wph  <= 1'b0;
      dcnt <= '0;
      ccnt <= '0;
    end else if (hact) begin
      wph <= cur_dw & ~wph;
      if (h_step) begin
        if (dcnt == DW'(CELL_W-1)) begin
          dcnt <= '0;
          if (col_next >= (CW+1)'(COLS)) hact <= 1'b0;
          else                           ccnt <= col_next[CW-1:0];
        end else begin
          dcnt <= dcnt + DW'(1);
        end
      end
    end
  end

  assign mem_row    = mrow;
  assign mem_col    = ccnt;
  assign glyph_line = gline;
  assign glyph_dot  = dcnt;
  assign active     = vact & hact & in_line;
  assign pwm_clk    = pwm_en & in_line & (pcnt < PW'(PWM_DIV/2));
endmodule

// File: rtl/osd_timing_seq_chk.sv
module osd_timing_seq_chk #(
  parameter int ROWS    = 15,
  parameter int COLS    = 30,
  parameter int CELL_W  = 10,
  parameter int GLYPH_H = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       hflb_n,
  input logic                       vflb_n,
  input logic                       pwm_en,
  input logic [ROWS-1:0]            row_dbl_w,
  input logic [$clog2(ROWS)-1:0]    mem_row,
  input logic [$clog2(COLS)-1:0]    mem_col,
  input logic [$clog2(CELL_W)-1:0]  glyph_dot,
  input logic                       active,
  input logic                       pwm_clk
);
  localparam int DW = $clog2(CELL_W);

  a_r11_line_edge_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hflb_n) |=> !active);

  a_r10_frame_edge_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vflb_n) |=> !active);

  a_r9_pwm_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hflb_n) |=> (pwm_clk == pwm_en));

  a_r9_pwm_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |-> !pwm_clk);

  a_r5_even_cols: assert property (@(posedge clk) disable iff (!rst_n)
    (active && row_dbl_w[mem_row]) |-> !mem_col[0]);

  a_r4_dot_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $stable(mem_row) && !row_dbl_w[mem_row]
     && ($past(glyph_dot) != DW'(CELL_W-1)))
    |-> (glyph_dot == $past(glyph_dot) + DW'(1)));

  a_r2_cell_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((glyph_dot < DW'(CELL_W)) && (int'(mem_col) < COLS)
                && (int'(mem_row) < ROWS)));
endmodule

bind osd_timing_seq osd_timing_seq_chk #(
  .ROWS(ROWS), .COLS(COLS), .CELL_W(CELL_W), .GLYPH_H(GLYPH_H)
) i_chk (
  .clk(clk), .rst_n(rst_n), .hflb_n(hflb_n), .vflb_n(vflb_n),
  .pwm_en(pwm_en), .row_dbl_w(row_dbl_w), .mem_row(mem_row),
  .mem_col(mem_col), .glyph_dot(glyph_dot), .active(active),
  .pwm_clk(pwm_clk)
);

// File: tb/test_osd_timing_seq.sv
module test_osd_timing_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hflb_n = 1'b1;
  logic        vflb_n = 1'b1;
  logic [7:0]  vdelay = 8'd1;
  logic [6:0]  hdelay = 7'd1;
  logic [5:0]  char_h = 6'd16;
  logic [1:0]  res_sel = 2'b11;
  logic        pwm_en = 1'b1;
  logic [14:0] row_dbl_h = '0;
  logic [14:0] row_dbl_w = '0;
  logic [3:0]  mem_row;
  logic [4:0]  mem_col;
  logic [3:0]  glyph_line;
  logic [3:0]  glyph_dot;
  logic        active;
  logic        pwm_clk;

  always #2 clk = ~clk;

  osd_timing_seq i_osd_timing_seq (
    .clk(clk), .rst_n(rst_n), .hflb_n(hflb_n), .vflb_n(vflb_n),
    .vdelay(vdelay), .hdelay(hdelay), .char_h(char_h), .res_sel(res_sel),
    .pwm_en(pwm_en), .row_dbl_h(row_dbl_h), .row_dbl_w(row_dbl_w),
    .mem_row(mem_row), .mem_col(mem_col), .glyph_line(glyph_line),
    .glyph_dot(glyph_dot), .active(active), .pwm_clk(pwm_clk)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  int  k = 2047;
  int  n = 0;
  bit  hp = 1;
  bit  vp = 1;
  int  pwm_rises;
  bit  pwm_prev;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d (line %0d dot %0d)", tag, what, act, exp, n, k);
    end
  endtask

  function automatic int line_len();
    if (!res_sel[0]) return 320;
    if (!res_sel[1]) return 480;
    return 640;
  endfunction

  function automatic void vexp(input int ln, output bit va, output int row, output int gl);
    int y;
    int h;
    y   = ln - (int'(vdelay) * 4 + 1);
    h   = int'(char_h);
    va  = 0;
    row = 0;
    gl  = 0;
    if (ln == 0 || y < 0) return;
    for (int r = 0; r < 15; r++) begin
      int ht;
      ht = row_dbl_h[r] ? 2 * h : h;
      if (y < ht) begin
        va  = 1;
        row = r;
        gl  = row_dbl_h[r] ? (y * 8) / h : (y * 16) / h;
        return;
      end
      y -= ht;
    end
  endfunction

  task automatic check_dot();
    bit    va;
    int    row, gl, hs, x, ll;
    bit    ea, ep;
    string t;
    vexp(n, va, row, gl);
    hs = int'(hdelay) * 5 + 47;
    x  = k - hs;
    ll = line_len();
    ea = va && x >= 0 && x < 300 && k < ll;
    if (k == 0)                                 t = "R11";
    else if (va && x >= 0 && x < 300 && k >= ll) t = "R8";
    else if (!va && n > int'(vdelay) * 4 + 1)   t = "R10";
    else if (!va)                               t = "R3";
    else                                        t = "R2";
    chk(t, "active", int'(active), int'(ea));
    if (ea && active) begin
      chk(row_dbl_h[row] ? "R7" : "R6", "mem_row", int'(mem_row), row);
      chk(row_dbl_h[row] ? "R7" : "R6", "glyph_line", int'(glyph_line), gl);
      if (row_dbl_w[row]) begin
        chk("R5", "mem_col", int'(mem_col), (x / 20) * 2);
        chk("R5", "glyph_dot", int'(glyph_dot), (x % 20) / 2);
      end else begin
        chk("R4", "mem_col", int'(mem_col), x / 10);
        chk("R4", "glyph_dot", int'(glyph_dot), x % 10);
      end
    end
    ep = pwm_en && k < ll && (k % 10) < 5;
    chk("R9", "pwm_clk", int'(pwm_clk), int'(ep));
    if (pwm_clk && !pwm_prev) pwm_rises++;
    pwm_prev = pwm_clk;
  endtask

  task automatic step();
    bit hfall, vfall;
    @(posedge clk);
    hfall = hp && !hflb_n;
    vfall = vp && !vflb_n;
    hp = hflb_n;
    vp = vflb_n;
    if (vfall) n = 0;
    else if (hfall && n < 2047) n++;
    if (hfall) k = 0;
    else if (k < 2047) k++;
    @(negedge clk);
    check_dot();
  endtask

  task automatic line(input int len);
    hflb_n    = 1'b0;
    pwm_rises = 0;
    pwm_prev  = 1'b0;
    for (int i = 0; i < len; i++) begin
      step();
      if (i == 2) hflb_n = 1'b1;
    end
    if (len >= line_len())
      chk("R9", "pwm periods per line", pwm_rises, pwm_en ? line_len() / 10 : 0);
  endtask

  task automatic vpulse();
    vflb_n = 1'b0;
    repeat (3) step();
    vflb_n = 1'b1;
    repeat (2) step();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "active after reset", int'(active), 0);
    chk("R1", "pwm_clk after reset", int'(pwm_clk), 0);
    repeat (20) step();
    chk("R1", "active before first line edge", int'(active), 0);

    // plain rows, 640-dot lines
    vpulse();
    for (int i = 1; i <= 250; i++) line((i % 25 == 0) ? 700 : 60);

    // height 21, double-height rows 1 and 14, double-width rows 2 and 5
    vdelay = 8'd2; char_h = 6'd21;
    row_dbl_h = 15'h4002; row_dbl_w = 15'h0024;
    vpulse();
    for (int i = 1; i <= 372; i++) line((i % 20 == 0) ? 400 : 60);

    // 320-dot lines truncate the run; row 0 double width
    vdelay = 8'd1; hdelay = 7'd3; char_h = 6'd16; res_sel = 2'b00;
    row_dbl_h = '0; row_dbl_w = 15'h0001;
    vpulse();
    for (int i = 1; i <= 8; i++) line(400);

    // frame restart in the middle of the display, 480-dot lines
    res_sel = 2'b01;
    vpulse();
    chk("R10", "active after mid-frame restart", int'(active), 0);
    for (int i = 1; i <= 7; i++) line(520);
    pwm_en = 1'b0;
    for (int i = 1; i <= 2; i++) line(520);
    pwm_en = 1'b1;
    res_sel = 2'b10;
    line(400);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule